// File: doc/BRIEF.md
# Indirect Per-Channel Division Factor Store

This block keeps one 15-bit division factor for each of five input clock channels. Each stored factor drives its channel's pre-divider continuously. The block sits on a byte-wide register port, so a factor wider than one byte cannot be written in a single access. Software loads it indirectly instead.

A load always takes three writes in the same order. First, software writes a 4-bit channel code to the pointer register. Next, it writes factor bits 7..0 to the low register, which only fills a staging byte. Last, it writes factor bits 14..8 to the high register. That final write places the whole 15-bit value into the entry the pointer selects, in a single clock edge. A pre-divider therefore never sees a half-written factor.

A stored value stays in place until the same channel is loaded again. Reads return the factor of the channel the pointer currently selects.

Top module: `fdiv_store`

## Requirements
- R1: After reset, every factor output is 0, the staging byte is 0, and the pointer holds code 0000, which selects no channel. Reads at all four addresses return 0.
- R2: A write to address 0 (pointer) stores `wr_data[3:0]` as the channel code. A read at address 0 returns that code in bits 3..0, with bits 7..4 at 0.
- R3: Channel codes map as follows: 0011 selects channel 0, 0100 channel 1, 0101 channel 2, 0110 channel 3 and 0111 channel 4. All other codes select no channel. At most one channel is ever committed at a time.
- R4: A write to address 1 (low) while a channel is selected loads `wr_data` into the staging byte only. No factor output and no read value changes.
- R5: A write to address 2 (high) while a channel is selected loads `{wr_data[6:0], staging byte}` into that channel's entry. The new value is visible on its factor output in the cycle after the write edge.
- R6: A commit to one channel leaves the factors of all other channels unchanged.
- R7: While the pointer holds an unmapped code, writes to address 1 and address 2 are ignored. The staging byte and all factors keep their values.
- R8: A read at address 1 returns bits 7..0 of the selected channel's stored factor. A read at address 2 returns bits 14..8 of that factor in bits 6..0, with bit 7 at 0. Both reads return 0 when no channel is selected.
- R9: A stored factor persists through any number of writes aimed at other channels or other registers, until its own channel is committed again.
- R10: On a high write, `wr_data[7]` is discarded.
- R11: Writes to address 3 change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address (0 pointer, 1 low, 2 high, 3 reserved) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| factor_o | output | 75 | Five 15-bit factors, channel k on bits 15k+14..15k |

## Verification
The hardest state to reach from the ports is a commit that uses a staging byte written much earlier. Two cases produce it. In the first, a low write is followed by a change of pointer and then only a high write. In the second, a low write made under an unmapped code must be shown to have left the staging byte untouched.

The directed tests build both sequences on purpose. After the lone high write, they check which low byte lands in the factor. They also check that a lone low write leaves every output and read value as it was.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int unsigned NUM_CH     = 5;
    localparam int unsigned FACT_W     = 15;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned CODE_W     = 4;
    localparam int unsigned CODE_FIRST = 3;

    typedef enum logic [1:0] {
        A_PTR = 2'd0,
        A_LO  = 2'd1,
        A_HI  = 2'd2,
        A_RSV = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/fdiv_sel_decode.sv
module fdiv_sel_decode #(
    parameter int unsigned NCH        = 5,
    parameter int unsigned SW         = 4,
    parameter int unsigned CODE_BASE  = 3,
    localparam int unsigned IW        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [SW-1:0]  code_i,
    output logic [NCH-1:0] hit_o,
    output logic [IW-1:0]  idx_o,
    output logic           valid_o
);
    // One comparator per channel against its assigned code.
    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign hit_o[g] = (code_i == SW'(CODE_BASE + g));
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit_o[i]) idx_o = IW'(i);
        end
    end

    assign valid_o = |hit_o;

    always_comb begin
        a_hit_onehot_r3: assert ($onehot0(hit_o));
    end
endmodule

// File: rtl/fdiv_entry.sv
module fdiv_entry #(
    parameter int unsigned FW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_i,
    input  logic [FW-1:0] data_i,
    output logic [FW-1:0] value_o
);
    logic [FW-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (commit_i) value_d = data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

    assign value_o = value_q;

    // Without a commit, the entry must hold its value.
    p_persist_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(value_o));
endmodule

// File: rtl/fdiv_readmux.sv
module fdiv_readmux
    import fdiv_pkg::*;
#(
    parameter int unsigned NCH = 5,
    parameter int unsigned FW  = 15,
    parameter int unsigned DW  = 8,
    parameter int unsigned SW  = 4,
    localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_i,
    input  logic [SW-1:0]     sel_i,
    input  logic              valid_i,
    input  logic [IW-1:0]     idx_i,
    input  logic [NCH*FW-1:0] factors_i,
    output logic [DW-1:0]     rd_o
);
    localparam int unsigned HW = FW - DW;

    logic [FW-1:0] cur;

    always_comb begin
        cur = '0;
        for (int i = 0; i < NCH; i++) begin
            if (valid_i && idx_i == IW'(i)) cur = factors_i[i*FW +: FW];
        end
    end

    always_comb begin
        rd_o = '0;
        case (reg_addr_e'(addr_i))
            A_PTR:   rd_o = {{(DW-SW){1'b0}}, sel_i};
            A_LO:    rd_o = cur[DW-1:0];
            A_HI:    rd_o = {{(DW-HW){1'b0}}, cur[FW-1:DW]};
            default: rd_o = '0;
        endcase
    end

    p_hi_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == A_HI) |-> (rd_o[DW-1] == 1'b0));

    p_unsel_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && addr_i != A_PTR) |-> (rd_o == '0));
endmodule

// File: rtl/fdiv_store.sv
module fdiv_store
    import fdiv_pkg::*;
#(
    parameter int unsigned NCH       = NUM_CH,
    parameter int unsigned FW        = FACT_W,
    parameter int unsigned DW        = BYTE_W,
    parameter int unsigned SW        = CODE_W,
    parameter int unsigned CODE_BASE = CODE_FIRST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic [NCH*FW-1:0] factor_o
);
    localparam int unsigned HW = FW - DW;
    localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [SW-1:0] sel;
        logic [DW-1:0] hold;
    } regs_t;

    regs_t st_d, st_q;

    logic [NCH-1:0] hit, commit;
    logic [IW-1:0]  idx;
    logic           sel_ok;
    logic           wr_ptr, wr_lo, wr_hi;
    logic [FW-1:0]  commit_val;

    fdiv_sel_decode #(.NCH(NCH), .SW(SW), .CODE_BASE(CODE_BASE)) u_dec (
        .code_i (st_q.sel),
        .hit_o  (hit),
        .idx_o  (idx),
        .valid_o(sel_ok)
    );

    assign wr_ptr = wr_en && (addr == A_PTR);
    assign wr_lo  = wr_en && (addr == A_LO);
    assign wr_hi  = wr_en && (addr == A_HI);

    always_comb begin
        st_d = st_q;
        if (wr_ptr)          st_d.sel  = wr_data[SW-1:0];
        if (wr_lo && sel_ok) st_d.hold = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit     = hit & {NCH{wr_hi}};
    assign commit_val = {wr_data[HW-1:0], st_q.hold};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        fdiv_entry #(.FW(FW)) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .commit_i(commit[g]),
            .data_i  (commit_val),
            .value_o (factor_o[g*FW +: FW])
        );

        p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hi && st_q.sel == SW'(CODE_BASE + g)) |=>
            (factor_o[g*FW +: FW] == {$past(wr_data[HW-1:0]), $past(st_q.hold)}));
    end

    fdiv_readmux #(.NCH(NCH), .FW(FW), .DW(DW), .SW(SW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr),
        .sel_i    (st_q.sel),
        .valid_i  (sel_ok),
        .idx_i    (idx),
        .factors_i(factor_o),
        .rd_o     (rd_data)
    );

    p_low_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> $stable(factor_o));

    p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_ok && addr != A_PTR) |=> ($stable(factor_o) && $stable(st_q.hold)));

    p_rsv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RSV) |=> ($stable(factor_o) && $stable(st_q)));

    p_one_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit));
endmodule

// File: tb/sim_fdiv_store.sv
module sim_fdiv_store;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 5;
    localparam int FW  = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [7:0]    wr_data = 8'd0;
    logic [7:0]    rd_data;
    logic [NCH*FW-1:0] factor_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [14:0] exp_f [NCH];
    logic [7:0]  exp_hold;

    fdiv_store u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .factor_o(factor_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [3:0] code_of(input int ch);
        return 4'(ch + 3);
    endfunction

    task automatic check_all(input string req);
        for (int i = 0; i < NCH; i++)
            check(req, {1'b0, factor_o[i*FW +: FW]}, {1'b0, exp_f[i]});
    endtask

    task automatic load(input int ch, input logic [14:0] v);
        wr(2'd0, {4'h0, code_of(ch)});
        wr(2'd1, v[7:0]);
        wr(2'd2, {1'b0, v[14:8]});
        exp_hold = v[7:0];
        exp_f[ch] = v;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check_all("R1 reset factor");
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reset read", {8'h0, d}, 16'h0);
        end
    endtask

    task automatic t_pointer();
        logic [7:0] d;
        wr(2'd0, 8'hF6);
        rd(2'd0, d);
        check("R2 pointer readback", {8'h0, d}, 16'h0006);
    endtask

    task automatic t_fill();
        logic [7:0] d;
        logic [14:0] vals [NCH];
        vals[0] = 15'h1234; vals[1] = 15'h7FFF; vals[2] = 15'h0101;
        vals[3] = 15'd23;   vals[4] = 15'h4ABC;
        for (int i = 0; i < NCH; i++) begin
            load(i, vals[i]);
            check("R5 commit visible", {1'b0, factor_o[i*FW +: FW]}, {1'b0, vals[i]});
        end
        check_all("R3 code map fill");
        for (int i = 0; i < NCH; i++) begin
            wr(2'd0, {4'h0, code_of(i)});
            rd(2'd1, d);
            check("R8 low readback", {8'h0, d}, {8'h0, vals[i][7:0]});
            rd(2'd2, d);
            check("R8 high readback", {8'h0, d}, {9'h0, vals[i][14:8]});
        end
    endtask

    task automatic t_rewrite();
        load(1, 15'h2A5A);
        check_all("R6 rewrite one channel");
        wr(2'd0, {4'h0, code_of(4)});
        wr(2'd0, {4'h0, code_of(0)});
        check_all("R9 persist over pointer writes");
    endtask

    task automatic t_lone_low();
        logic [7:0] d;
        logic [74:0] snap;
        wr(2'd0, {4'h0, code_of(2)});
        snap = factor_o;
        wr(2'd1, 8'hC3);
        check("R4 lone low outputs", {15'h0, factor_o == snap}, 16'h1);
        rd(2'd1, d);
        check("R4 lone low readback", {8'h0, d}, {8'h0, exp_f[2][7:0]});
        wr(2'd0, {4'h0, code_of(3)});
        wr(2'd2, 8'h05);
        exp_f[3] = {7'h05, 8'hC3};
        exp_hold = 8'hC3;
        check_all("R5 staging byte carried across pointer change");
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        logic [3:0] bad_codes [4];
        bad_codes[0] = 4'h0; bad_codes[1] = 4'h2;
        bad_codes[2] = 4'h8; bad_codes[3] = 4'hF;
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, {4'h0, bad_codes[k]});
            wr(2'd1, 8'h99);
            wr(2'd2, 8'h3E);
            check_all("R7 unmapped writes ignored");
            rd(2'd1, d);
            check("R3 unmapped low read", {8'h0, d}, 16'h0);
            rd(2'd2, d);
            check("R8 unmapped high read", {8'h0, d}, 16'h0);
        end
        wr(2'd0, {4'h0, code_of(0)});
        wr(2'd2, 8'h11);
        exp_f[0] = {7'h11, exp_hold};
        check_all("R7 staging untouched by unmapped low");
    endtask

    task automatic t_bit7();
        logic [7:0] d;
        wr(2'd0, {4'h0, code_of(4)});
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        exp_f[4] = 15'h7FFF;
        exp_hold = 8'hFF;
        check_all("R10 high bit7 dropped");
        rd(2'd2, d);
        check("R8 high read bit7 zero", {8'h0, d}, 16'h007F);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        logic [7:0] p;
        rd(2'd0, p);
        wr(2'd3, 8'hA7);
        check_all("R11 reserved write ignored");
        rd(2'd3, d);
        check("R11 reserved read", {8'h0, d}, 16'h0);
        rd(2'd0, d);
        check("R11 pointer unchanged", {8'h0, d}, {8'h0, p});
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) exp_f[i] = '0;
        exp_hold = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_fill();
        t_rewrite();
        t_lone_low();
        t_unmapped();
        t_bit7();
        t_reserved();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule